// File: doc/BRIEF.md
# Staged Clock Switch Sequencer

This block moves a processor core clock and a system clock off a crystal reference and onto a PLL output. It does so in stages, so that the two domains never see a glitch and never fall out of phase alignment. It owns three register-style outputs: a core source select, a core divider code and a system divider code. The clock multiplexer, PLL and dividers that read these codes are not part of the block.

A request starts a fixed sequence of five writes:

1. Fall back to the crystal on all three codes.
2. Pre-divide the core clock by two.
3. Set the core-to-system ratio.
4. Select the PLL.
5. Remove the pre-divide.

A settle counter runs on the always-running reference clock and must expire between any two writes. The settle length and the profile are captured when the request is accepted. The full-speed profile sets the system divider to divide-by-two, for a 1:2 ratio. The half-speed profile sets it to divide-by-one, for a 1:1 ratio. With a 40 MHz crystal and a 400 MHz PLL, the full-speed core goes from 40 MHz to 200 MHz and then to 400 MHz.

Each output code is `NUM_LANES` fields of `LANE_W` bits, and the encodings apply to every field alike:

| Meaning | Encoding per field | Whole code with default parameters |
|---|---|---|
| Crystal source, or divide-by-one | all zeros | 6'b000000 |
| Divide-by-two | all ones | 6'b111111 |
| PLL source | value 2 | 6'b101010 |

Top module: `staged_clk_switch`

## Requirements
- R1: A synchronous reset drives all three codes to zero (crystal and divide-by-one), busy low and done low.
- R2: A start request sampled while idle writes zero into all three codes on that same clock edge, and busy is high from the next cycle.
- R3: The second write sets the core divider to all ones (divide-by-two) and leaves the source select and the system divider unchanged.
- R4: The third write sets the system divider to all ones when the captured profile is full speed (input 1), and to all zeros when it is half speed (input 0). The other two codes are unchanged.
- R5: The fourth write sets the source select to the PLL code, value 2 in each field (6'b101010 by default), with both dividers unchanged.
- R6: The fifth write sets the core divider to all zeros (divide-by-one) and leaves the other two codes unchanged.
- R7: With settle value S captured at start, each write after the first lands exactly S+1 clock edges after the previous one. All three codes hold in between.
- R8: A start request that arrives while busy, or in the done cycle, is ignored: no code changes and no sequence restarts.
- R9: The profile and the settle value are captured when the request is accepted. Changes to those inputs during the sequence have no effect.
- R10: Done is high for exactly one cycle, right after the fifth write, with busy low. The block is then idle and accepts a new start.
- R11: The source select takes the PLL code only while the core divider holds divide-by-two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (always running) |
| rst | input | 1 | Synchronous reset, active high |
| start_req | input | 1 | Request to run the switch sequence |
| full_speed | input | 1 | Profile: 1 full-speed core (1:2 ratio), 0 half-speed core (1:1 ratio) |
| settle_cycles | input | CNT_W | Settle length in reference cycles between writes |
| core_src_sel | output | NUM_LANES*LANE_W | Core clock source select code |
| core_div_val | output | NUM_LANES*LANE_W | Core clock divider code |
| sys_div_val | output | NUM_LANES*LANE_W | System clock divider code |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse after the last write |

## Verification
The clocked assertions assume that reset is held from time zero until the first clock edges have passed. They also assume that the profile and settle inputs matter only on the cycle a start is accepted, so they make no claim about those inputs at other times. The stimulus holds reset across the first cycles and drives every input at the falling edge. It deliberately changes the profile, the settle value and the start request while a sequence is running, so the capture and ignore rules are tested rather than assumed.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;

   typedef enum logic [2:0] {
      STP_NONE   = 3'd0,
      STP_XTAL   = 3'd1,
      STP_PREDIV = 3'd2,
      STP_RATIO  = 3'd3,
      STP_PLL    = 3'd4,
      STP_UNDIV  = 3'd5
   } step_e;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_WAIT = 2'd1,
      SEQ_FIN  = 2'd2
   } seq_state_e;

   function automatic step_e step_after(step_e s);
      case (s)
         STP_NONE:   return STP_XTAL;
         STP_XTAL:   return STP_PREDIV;
         STP_PREDIV: return STP_RATIO;
         STP_RATIO:  return STP_PLL;
         STP_PLL:    return STP_UNDIV;
         default:    return STP_NONE;
      endcase
   endfunction

endpackage

// File: rtl/clkseq_settle_timer.sv
module clkseq_settle_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

   // R7
   settle_count_down_chk: assert property (@(posedge clk) disable iff (rst)
      (!load && !expired) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/clkseq_step_fsm.sv
module clkseq_step_fsm
   import clkseq_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start_req,
   input  logic             full_speed,
   input  logic [CNT_W-1:0] settle_cycles,
   input  logic             tmr_expired,
   output logic             tmr_load,
   output logic [CNT_W-1:0] tmr_val,
   output logic             wr_en,
   output step_e            wr_step,
   output logic             prof_full,
   output logic             busy,
   output logic             done
);

   seq_state_e       state_q;
   seq_state_e       state_d;
   step_e            step_q;
   logic [CNT_W-1:0] settle_q;
   logic             prof_q;
   logic             accept;

   assign accept = (state_q == SEQ_IDLE) && start_req;

   always_comb begin
      state_d  = state_q;
      wr_en    = 1'b0;
      wr_step  = step_q;
      tmr_load = 1'b0;
      case (state_q)
         SEQ_IDLE: begin
            if (start_req) begin
               wr_en    = 1'b1;
               wr_step  = STP_XTAL;
               tmr_load = 1'b1;
               state_d  = SEQ_WAIT;
            end
         end
         SEQ_WAIT: begin
            if (tmr_expired) begin
               wr_en   = 1'b1;
               wr_step = step_after(step_q);
               if (step_after(step_q) == STP_UNDIV) begin
                  state_d = SEQ_FIN;
               end else begin
                  tmr_load = 1'b1;
               end
            end
         end
         SEQ_FIN: state_d = SEQ_IDLE;
         default: state_d = SEQ_IDLE;
      endcase
   end

   // First load comes straight from the port; later loads use the captured value.
   assign tmr_val = (state_q == SEQ_IDLE) ? settle_cycles : settle_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q  <= SEQ_IDLE;
         step_q   <= STP_NONE;
         settle_q <= '0;
         prof_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            settle_q <= settle_cycles;
            prof_q   <= full_speed;
         end
         if (wr_en) begin
            step_q <= wr_step;
         end else if (state_q == SEQ_FIN) begin
            step_q <= STP_NONE;
         end
      end
   end

   assign prof_full = prof_q;
   assign busy      = (state_q == SEQ_WAIT);
   assign done      = (state_q == SEQ_FIN);

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      done |=> (!done && !busy));

   // R10
   done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
      !(done && busy));

   // R8
   start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
      ((busy || done) && start_req) |-> !(wr_en && wr_step == STP_XTAL));

   // R9
   profile_hold_chk: assert property (@(posedge clk) disable iff (rst)
      busy |=> $stable(prof_q));

endmodule

// File: rtl/clkseq_out_regs.sv
module clkseq_out_regs
   import clkseq_pkg::*;
#(
   parameter int NUM_LANES = 3,
   parameter int LANE_W    = 2,
   localparam int OUT_W    = NUM_LANES * LANE_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  step_e            wr_step,
   input  logic             prof_full,
   output logic [OUT_W-1:0] src_sel,
   output logic [OUT_W-1:0] core_div,
   output logic [OUT_W-1:0] sys_div
);

   logic [OUT_W-1:0] pll_code;
   logic [OUT_W-1:0] div2_code;

   for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
      assign pll_code[l*LANE_W +: LANE_W]  = LANE_W'(2);
      assign div2_code[l*LANE_W +: LANE_W] = {LANE_W{1'b1}};
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         src_sel  <= '0;
         core_div <= '0;
         sys_div  <= '0;
      end else if (wr_en) begin
         case (wr_step)
            STP_XTAL: begin
               src_sel  <= '0;
               core_div <= '0;
               sys_div  <= '0;
            end
            STP_PREDIV: core_div <= div2_code;
            STP_RATIO:  sys_div  <= prof_full ? div2_code : '0;
            STP_PLL:    src_sel  <= pll_code;
            STP_UNDIV:  core_div <= '0;
            default: ;
         endcase
      end
   end

   // R11
   pll_after_prediv_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_step == STP_PLL) |-> (core_div == div2_code));

   // R3
   src_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && (wr_step == STP_PREDIV || wr_step == STP_RATIO || wr_step == STP_UNDIV))
      |=> $stable(src_sel));

   // R5
   div_hold_on_pll_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_step == STP_PLL) |=> ($stable(core_div) && $stable(sys_div)));

endmodule

// File: rtl/staged_clk_switch.sv
module staged_clk_switch
   import clkseq_pkg::*;
#(
   parameter int NUM_LANES = 3,
   parameter int LANE_W    = 2,
   parameter int CNT_W     = 16
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        start_req,
   input  logic                        full_speed,
   input  logic [CNT_W-1:0]            settle_cycles,
   output logic [NUM_LANES*LANE_W-1:0] core_src_sel,
   output logic [NUM_LANES*LANE_W-1:0] core_div_val,
   output logic [NUM_LANES*LANE_W-1:0] sys_div_val,
   output logic                        busy,
   output logic                        done
);

   if (LANE_W < 2) begin : g_bad_lane
      $error("LANE_W must be at least 2 to hold the PLL code");
   end
   if (NUM_LANES < 1) begin : g_bad_lanes
      $error("NUM_LANES must be at least 1");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be at least 1");
   end

   logic             tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic             tmr_expired;
   logic             wr_en;
   step_e            wr_step;
   logic             prof_full;

   clkseq_settle_timer #(.CNT_W(CNT_W)) i_timer (
      .clk      (clk),
      .rst      (rst),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_expired)
   );

   clkseq_step_fsm #(.CNT_W(CNT_W)) i_fsm (
      .clk           (clk),
      .rst           (rst),
      .start_req     (start_req),
      .full_speed    (full_speed),
      .settle_cycles (settle_cycles),
      .tmr_expired   (tmr_expired),
      .tmr_load      (tmr_load),
      .tmr_val       (tmr_val),
      .wr_en         (wr_en),
      .wr_step       (wr_step),
      .prof_full     (prof_full),
      .busy          (busy),
      .done          (done)
   );

   clkseq_out_regs #(.NUM_LANES(NUM_LANES), .LANE_W(LANE_W)) i_regs (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (wr_en),
      .wr_step   (wr_step),
      .prof_full (prof_full),
      .src_sel   (core_src_sel),
      .core_div  (core_div_val),
      .sys_div   (sys_div_val)
   );

   // R7
   settle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (busy && !tmr_expired)
      |=> ($stable(core_src_sel) && $stable(core_div_val) && $stable(sys_div_val)));

   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!busy && !start_req)
      |=> ($stable(core_src_sel) && $stable(core_div_val) && $stable(sys_div_val)));

endmodule

// File: tb/test_staged_clk_switch.sv
module test_staged_clk_switch;

   localparam int CLK_PERIOD = 10;
   localparam int CNT_W      = 16;
   localparam logic [5:0] PLL_E  = 6'b101010;
   localparam logic [5:0] DIV2_E = 6'b111111;
   localparam int NV = 6;
   // {disturb, full_speed, settle}
   localparam logic [17:0] VEC [NV] = '{
      {1'b0, 1'b1, 16'd0},
      {1'b0, 1'b0, 16'd0},
      {1'b1, 1'b1, 16'd3},
      {1'b1, 1'b0, 16'd2},
      {1'b0, 1'b1, 16'd7},
      {1'b1, 1'b0, 16'd1}
   };

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic start_req = 1'b0;
   logic full_speed = 1'b0;
   logic [CNT_W-1:0] settle_cycles = '0;
   logic [5:0] core_src_sel, core_div_val, sys_div_val;
   logic busy, done;
   int tests = 0;
   int fails = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   staged_clk_switch #(.NUM_LANES(3), .LANE_W(2), .CNT_W(CNT_W)) i_staged_clk_switch (
      .clk(clk), .rst(rst), .start_req(start_req), .full_speed(full_speed),
      .settle_cycles(settle_cycles), .core_src_sel(core_src_sel),
      .core_div_val(core_div_val), .sys_div_val(sys_div_val),
      .busy(busy), .done(done)
   );

   function automatic logic [17:0] exp_out(logic prof, int k);
      logic [5:0] s, c, y;
      s = '0; c = '0; y = '0;
      if (k >= 2) c = DIV2_E;
      if (k >= 3) y = prof ? DIV2_E : 6'b0;
      if (k >= 4) s = PLL_E;
      if (k >= 5) c = 6'b0;
      return {s, c, y};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] outs();
      return {14'b0, core_src_sel, core_div_val, sys_div_val};
   endfunction

   task automatic run_seq(input logic prof, input logic [CNT_W-1:0] s, input logic disturb);
      string tag;
      @(negedge clk);
      full_speed = prof; settle_cycles = s; start_req = 1'b1;
      @(negedge clk);
      start_req = 1'b0;
      if (disturb) begin
         full_speed = ~prof;            // R9: changes after capture
         settle_cycles = s + 16'd5;
      end
      check("R2", outs(), {14'b0, exp_out(prof, 1)});
      check("R2 busy", {31'b0, busy}, 32'd1);
      for (int k = 2; k <= 5; k++) begin
         for (int i = 0; i < int'(s); i++) begin
            if (disturb && i == 0) start_req = 1'b1;   // R8: request while busy
            @(negedge clk);
            start_req = 1'b0;
            check("R7 R8 R9 hold", outs(), {14'b0, exp_out(prof, k - 1)});
         end
         @(negedge clk);
         case (k)
            2: tag = "R3";
            3: tag = "R4 R9";
            4: tag = "R5 R11";
            default: tag = "R6";
         endcase
         check(tag, outs(), {14'b0, exp_out(prof, k)});
      end
      check("R10 done", {30'b0, done, busy}, 32'd2);
      if (disturb) start_req = 1'b1;   // R8: request in done cycle
      @(negedge clk);
      start_req = 1'b0;
      check("R10 idle", {30'b0, done, busy}, 32'd0);
      check("R8 no restart", outs(), {14'b0, exp_out(prof, 5)});
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", outs(), 32'd0);
      check("R1 flags", {30'b0, done, busy}, 32'd0);
      rst = 1'b0;
      @(negedge clk);
      check("R1 after release", outs(), 32'd0);

      for (int v = 0; v < NV; v++) begin
         run_seq(VEC[v][16], VEC[v][15:0], VEC[v][17]);
      end

      // R1: reset in the middle of a sequence
      @(negedge clk);
      full_speed = 1'b1; settle_cycles = 16'd4; start_req = 1'b1;
      @(negedge clk);
      start_req = 1'b0;
      repeat (12) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check("R1 mid-seq", outs(), 32'd0);
      check("R1 mid-seq flags", {30'b0, done, busy}, 32'd0);
      repeat (6) @(negedge clk);
      check("R1 stays idle", {30'b0, done, busy}, 32'd0);
      check("R1 codes hold", outs(), 32'd0);

      // R10: new start accepted right after reset recovery
      run_seq(1'b0, 16'd1, 1'b0);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule